// File: doc/BRIEF.md
# Channel Set/Clear Control Bank

This block is the control and status register bank of a multi-channel DMA engine. It keeps four per-channel bitmaps: which channels may accept hardware requests, which channels may raise the error interrupt, which channels have a completion interrupt pending, and which channels have an error pending. Software reads each bitmap as a 32-bit word. To change the bit of one channel, software writes the channel's index as a single byte to a dedicated port. Each port either sets or clears one kind of bit, so no read-modify-write is needed and two agents cannot overwrite each other's bits.

Hardware sources raise the pending bits with single-cycle pulses. The bank drives a completion interrupt and an error interrupt built from those bits. It also holds a global control word, which includes the arbitration-mode bits. Two byte ports do not store anything. Instead they issue one-cycle per-channel strobes: one starts a channel and one clears its done flag. The transfer datapath and the arbiter sit outside this block.

Top module: `dma_chan_ctl_bank`

## Requirements
- R1: After reset, every bitmap, the control word, the error status word and all outputs (`ctrl_o`, `req_en_o`, `start_o`, `done_clr_o`, `irq_o`, `err_irq_o`) are zero.
- R2: A byte write to the set-request-enable port (0x1B) or the set-error-interrupt-enable port (0x19) sets only the bit of the channel given by bits 4:0 of the byte. Bits 7:5 of the byte are ignored.
- R3: A byte write to the clear-request-enable port (0x1A) or the clear-error-interrupt-enable port (0x18) clears only the bit of the selected channel.
- R4: A byte write to the clear-interrupt port (0x1F) clears only the selected bit of the interrupt-pending bitmap (0x24). A byte write to the clear-error port (0x1E) does the same for the error-pending bitmap (0x2C). Word writes to 0x24 and 0x2C change nothing.
- R5: A pulse on bit N of `hw_int_set` or `hw_err_set` sets bit N of the matching pending bitmap at the next clock edge. When such a pulse and a software clear of the same bit arrive in the same cycle, the bit ends up set.
- R6: `irq_o` is the OR of all interrupt-pending bits. `err_irq_o` is the OR of the error-pending bits whose error-interrupt-enable bit is set.
- R7: A word write to 0x00 stores only the defined control bits (mask 0x0003_00FE). These are: bit 1 debug, bit 2 round-robin channel arbitration, bit 3 round-robin group arbitration, bit 4 halt on error, bit 5 halt, bit 6 continuous link, bit 7 minor-loop mapping, bit 16 cancel and bit 17 error-cancel. Bits 16 and 17 read back for one cycle and then clear themselves. `ctrl_o` mirrors the stored word.
- R8: A byte write of channel N to the start port (0x1D) makes `start_o` equal to one-hot bit N for exactly the one cycle after the write. The clear-done port (0x1C) does the same on `done_clr_o`.
- R9: A word write to 0x0C replaces the whole request-enable bitmap, and a word write to 0x14 replaces the whole error-interrupt-enable bitmap. `req_en_o` mirrors the request-enable bitmap.
- R10: The error status word (0x04) reads bit 31 = 1 when any error bit is pending. Bits 4:0 hold the channel of the most recent hardware error pulse, and among simultaneous pulses the lowest channel is taken.
- R11: Reads of unmapped offsets return zero. A byte write to a non-port offset changes nothing, and a word write to a port offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_word | input | 1 | 1 = 32-bit word write, 0 = byte write on bits 7:0 |
| bus_addr | input | ADDR_W | Write byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rd_addr | input | ADDR_W | Read byte offset |
| bus_rdata | output | 32 | Read data (combinational) |
| hw_int_set | input | NUM_CH | Per-channel completion pulses |
| hw_err_set | input | NUM_CH | Per-channel error pulses |
| ctrl_o | output | 32 | Global control word |
| req_en_o | output | NUM_CH | Request-enable bitmap |
| start_o | output | NUM_CH | One-cycle channel start strobes |
| done_clr_o | output | NUM_CH | One-cycle done-clear strobes |
| irq_o | output | 1 | Completion interrupt |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The bench targets four corner cases, each tied to a specific wrong design:

- **Simultaneous hardware set and software clear of the same pending bit.** A bank that lets the clear win silently drops a completion event.
- **Port bytes with the upper three bits set.** A decoder that uses the whole byte would miss the channel.
- **Word writes to port or pending offsets, and byte writes to bitmap offsets.** A loose decoder would corrupt a bitmap here.
- **Pending errors on channels with and without the error-interrupt enable.** A design that forgets the enable mask raises `err_irq_o` when it should not.

Beyond these, the bench checks the following:

- The cancel bits must drop one cycle after they are written.
- The start and done-clear strobes must last exactly one cycle.
- The error status channel field must pick the lowest channel when two errors arrive together.

// File: rtl/dma_bank_pkg.sv
package dma_bank_pkg;

    localparam int REG_W     = 32;
    localparam int CH_IDX_W  = 5;
    localparam int NUM_PORTS = 8;

    // word-wide register offsets
    localparam logic [7:0] OFS_CTRL      = 8'h00;
    localparam logic [7:0] OFS_ERR_STAT  = 8'h04;
    localparam logic [7:0] OFS_REQ_EN    = 8'h0C;
    localparam logic [7:0] OFS_ERR_IE    = 8'h14;
    localparam logic [7:0] OFS_INT_PEND  = 8'h24;
    localparam logic [7:0] OFS_ERR_PEND  = 8'h2C;

    // first byte-wide port; port p sits at OFS_PORT_BASE + p
    localparam logic [7:0] OFS_PORT_BASE = 8'h18;

    typedef enum logic [2:0] {
        PORT_CLR_EIE   = 3'd0,
        PORT_SET_EIE   = 3'd1,
        PORT_CLR_REQ   = 3'd2,
        PORT_SET_REQ   = 3'd3,
        PORT_CLR_DONE  = 3'd4,
        PORT_SET_START = 3'd5,
        PORT_CLR_ERR   = 3'd6,
        PORT_CLR_INT   = 3'd7
    } port_e;

    // control word: defined bits and the bits that drop after one cycle
    localparam logic [REG_W-1:0] CTRL_MASK     = 32'h0003_00FE;
    localparam logic [REG_W-1:0] CTRL_SELF_CLR = 32'h0003_0000;

endpackage

// File: rtl/dma_bank_port_decode.sv
module dma_bank_port_decode
    import dma_bank_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 8
) (
    input  logic                                wr_en,
    input  logic                                wr_word,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [CH_IDX_W-1:0]                 idx,
    output logic [NUM_PORTS-1:0][NUM_CH-1:0]    port_oh,
    output logic                                wr_ctrl,
    output logic                                wr_req_en,
    output logic                                wr_err_ie
);

    logic [NUM_CH-1:0] chan_oh;

    // channel index to one-hot; indices at or above NUM_CH select nothing
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign chan_oh[c] = (idx == CH_IDX_W'(c));
    end

    // one byte-wide strobe vector per port
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(int'(OFS_PORT_BASE) + p);
        assign port_oh[p] = (wr_en && !wr_word && addr == PORT_ADDR) ? chan_oh : '0;
    end

    assign wr_ctrl   = wr_en && wr_word && addr == ADDR_W'(OFS_CTRL);
    assign wr_req_en = wr_en && wr_word && addr == ADDR_W'(OFS_REQ_EN);
    assign wr_err_ie = wr_en && wr_word && addr == ADDR_W'(OFS_ERR_IE);

endmodule

// File: rtl/dma_bank_flag_map.sv
module dma_bank_flag_map #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_oh,
    input  logic [NUM_CH-1:0] clr_oh,
    input  logic              word_wr,
    input  logic [NUM_CH-1:0] word_data,
    input  logic [NUM_CH-1:0] hw_set,
    output logic [NUM_CH-1:0] bits_q
);

    logic [NUM_CH-1:0] bits_d;

    always_comb begin
        bits_d = bits_q;
        if (word_wr) begin
            bits_d = word_data;
        end
        bits_d = (bits_d | set_oh) & ~clr_oh;
        // hardware events are applied last so they are never lost
        bits_d = bits_d | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    // R5: a hardware pulse always leaves its bit set
    a_r5_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((bits_q & $past(hw_set)) == $past(hw_set)));

    // R3: a lone software clear removes exactly one channel
    a_r3_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_oh != '0 && hw_set == '0 && set_oh == '0 && !word_wr)
        |=> (bits_q == ($past(bits_q) & ~$past(clr_oh))));

    // R2: a lone software set adds its channel and leaves the others alone
    a_r2_set_single: assert property (@(posedge clk) disable iff (!rst_n)
        (set_oh != '0 && hw_set == '0 && clr_oh == '0 && !word_wr)
        |=> (bits_q == ($past(bits_q) | $past(set_oh))));

endmodule

// File: rtl/dma_chan_ctl_bank.sv
module dma_chan_ctl_bank
    import dma_bank_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_wr_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [ADDR_W-1:0] bus_rd_addr,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] hw_int_set,
    input  logic [NUM_CH-1:0] hw_err_set,
    output logic [31:0]       ctrl_o,
    output logic [NUM_CH-1:0] req_en_o,
    output logic [NUM_CH-1:0] start_o,
    output logic [NUM_CH-1:0] done_clr_o,
    output logic              irq_o,
    output logic              err_irq_o
);

    typedef struct packed {
        logic [REG_W-1:0]    ctrl;
        logic [CH_IDX_W-1:0] last_err;
        logic [NUM_CH-1:0]   start;
        logic [NUM_CH-1:0]   done_clr;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic [NUM_PORTS-1:0][NUM_CH-1:0] port_oh;
    logic              wr_ctrl, wr_req_en, wr_err_ie;
    logic [NUM_CH-1:0] req_en_q, err_ie_q, int_pend_q, err_pend_q;

    dma_bank_port_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .wr_en     (bus_wr_en),
        .wr_word   (bus_wr_word),
        .addr      (bus_addr),
        .idx       (bus_wdata[CH_IDX_W-1:0]),
        .port_oh   (port_oh),
        .wr_ctrl   (wr_ctrl),
        .wr_req_en (wr_req_en),
        .wr_err_ie (wr_err_ie)
    );

    dma_bank_flag_map #(.NUM_CH(NUM_CH)) u_req_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_oh    (port_oh[PORT_SET_REQ]),
        .clr_oh    (port_oh[PORT_CLR_REQ]),
        .word_wr   (wr_req_en),
        .word_data (bus_wdata[NUM_CH-1:0]),
        .hw_set    ('0),
        .bits_q    (req_en_q)
    );

    dma_bank_flag_map #(.NUM_CH(NUM_CH)) u_err_ie (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_oh    (port_oh[PORT_SET_EIE]),
        .clr_oh    (port_oh[PORT_CLR_EIE]),
        .word_wr   (wr_err_ie),
        .word_data (bus_wdata[NUM_CH-1:0]),
        .hw_set    ('0),
        .bits_q    (err_ie_q)
    );

    dma_bank_flag_map #(.NUM_CH(NUM_CH)) u_int_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_oh    ('0),
        .clr_oh    (port_oh[PORT_CLR_INT]),
        .word_wr   (1'b0),
        .word_data ('0),
        .hw_set    (hw_int_set),
        .bits_q    (int_pend_q)
    );

    dma_bank_flag_map #(.NUM_CH(NUM_CH)) u_err_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_oh    ('0),
        .clr_oh    (port_oh[PORT_CLR_ERR]),
        .word_wr   (1'b0),
        .word_data ('0),
        .hw_set    (hw_err_set),
        .bits_q    (err_pend_q)
    );

    // next-state logic for the control word, error channel and strobes
    always_comb begin
        st_d          = st_q;
        st_d.ctrl     = st_q.ctrl & ~CTRL_SELF_CLR;
        if (wr_ctrl) begin
            st_d.ctrl = bus_wdata & CTRL_MASK;
        end
        st_d.start    = port_oh[PORT_SET_START];
        st_d.done_clr = port_oh[PORT_CLR_DONE];
        // scan high to low so the lowest pulsing channel is kept
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (hw_err_set[i]) begin
                st_d.last_err = CH_IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        case (bus_rd_addr)
            ADDR_W'(OFS_CTRL):     bus_rdata = st_q.ctrl;
            ADDR_W'(OFS_ERR_STAT): bus_rdata = {(|err_pend_q), {(REG_W-CH_IDX_W-1){1'b0}}, st_q.last_err};
            ADDR_W'(OFS_REQ_EN):   bus_rdata = 32'(req_en_q);
            ADDR_W'(OFS_ERR_IE):   bus_rdata = 32'(err_ie_q);
            ADDR_W'(OFS_INT_PEND): bus_rdata = 32'(int_pend_q);
            ADDR_W'(OFS_ERR_PEND): bus_rdata = 32'(err_pend_q);
            default:               bus_rdata = '0;
        endcase
    end

    assign ctrl_o     = st_q.ctrl;
    assign req_en_o   = req_en_q;
    assign start_o    = st_q.start;
    assign done_clr_o = st_q.done_clr;
    assign irq_o      = |int_pend_q;
    assign err_irq_o  = |(err_pend_q & err_ie_q);

    // R7: cancel bits drop one cycle after they appear unless rewritten
    a_r7_cancel_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl[17:16] != 2'b00 && !wr_ctrl) |=> (st_q.ctrl[17:16] == 2'b00));

    // R8: at most one channel is started per cycle
    a_r8_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_o) && $onehot0(done_clr_o));

    // R6: a hardware completion pulse raises the interrupt next cycle
    a_r6_irq_follows_hw: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_int_set != '0) |=> irq_o);

    // R6: the error interrupt needs at least one enabled channel
    a_r6_err_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |-> (err_ie_q != '0));

    // R10: a hardware error leaves the status flag set
    a_r10_status_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_err_set != '0) |=> bus_rd_addr != ADDR_W'(OFS_ERR_STAT) || bus_rdata[31]);

endmodule

// File: tb/dma_chan_ctl_bank_tb_top.sv
`timescale 1ns/100ps
module dma_chan_ctl_bank_tb_top;

    localparam int NUM_CH = 32;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic              bus_wr_word = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [ADDR_W-1:0] bus_rd_addr = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] hw_int_set = '0;
    logic [NUM_CH-1:0] hw_err_set = '0;
    logic [31:0]       ctrl_o;
    logic [NUM_CH-1:0] req_en_o, start_o, done_clr_o;
    logic              irq_o, err_irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_chan_ctl_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_wr_en (bus_wr_en), .bus_wr_word (bus_wr_word),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rd_addr (bus_rd_addr), .bus_rdata (bus_rdata),
        .hw_int_set (hw_int_set), .hw_err_set (hw_err_set),
        .ctrl_o (ctrl_o), .req_en_o (req_en_o), .start_o (start_o),
        .done_clr_o (done_clr_o), .irq_o (irq_o), .err_irq_o (err_irq_o)
    );

    typedef struct packed {
        logic        word;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h1B, 32'h0000_0003, 8'h0C, 32'h0000_0008, 8'd2},  // R2 set req ch3
        '{1'b0, 8'h1B, 32'h0000_00E5, 8'h0C, 32'h0000_0028, 8'd2},  // R2 upper bits ignored
        '{1'b0, 8'h1A, 32'h0000_0003, 8'h0C, 32'h0000_0020, 8'd3},  // R3 clear req ch3
        '{1'b1, 8'h0C, 32'hF0F0_0001, 8'h0C, 32'hF0F0_0001, 8'd9},  // R9 word write
        '{1'b0, 8'h19, 32'h0000_001F, 8'h14, 32'h8000_0000, 8'd2},  // R2 set err-ie ch31
        '{1'b0, 8'h19, 32'h0000_0000, 8'h14, 32'h8000_0001, 8'd2},  // R2 set err-ie ch0
        '{1'b0, 8'h18, 32'h0000_001F, 8'h14, 32'h0000_0001, 8'd3},  // R3 clear err-ie ch31
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 8'h00, 32'h0003_00FE, 8'd7},  // R7 masked write
        '{1'b1, 8'h00, 32'h0000_0024, 8'h00, 32'h0000_0024, 8'd7},  // R7 plain write
        '{1'b0, 8'h0C, 32'h0000_0007, 8'h0C, 32'hF0F0_0001, 8'd11}, // R11 byte to bitmap
        '{1'b1, 8'h1B, 32'h0000_0002, 8'h0C, 32'hF0F0_0001, 8'd11}, // R11 word to port
        '{1'b1, 8'h24, 32'hFFFF_FFFF, 8'h24, 32'h0000_0000, 8'd4},  // R4 word to pending
        '{1'b1, 8'h30, 32'hFFFF_FFFF, 8'h30, 32'h0000_0000, 8'd11}, // R11 unmapped
        '{1'b1, 8'h14, 32'h0000_0000, 8'h14, 32'h0000_0000, 8'd9}   // R9 word clear
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input int req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one bus cycle; drive at a falling edge, release at the next one
    task automatic cycle(input logic en, input logic word, input logic [7:0] addr,
                         input logic [31:0] data, input logic [NUM_CH-1:0] hwi,
                         input logic [NUM_CH-1:0] hwe);
        @(negedge clk);
        bus_wr_en = en; bus_wr_word = word; bus_addr = addr; bus_wdata = data;
        hw_int_set = hwi; hw_err_set = hwe;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wr_word = 1'b0; hw_int_set = '0; hw_err_set = '0;
    endtask

    task automatic rd(input logic [7:0] addr, output logic [31:0] val);
        bus_rd_addr = addr;
        #0.5;
        val = bus_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        foreach (VECS[i]) begin
            rd(VECS[i].raddr, v);
            check(v, 32'h0, 1, "reset register");
        end
        rd(8'h04, v); check(v, 32'h0, 1, "reset error status");
        check({irq_o, err_irq_o}, 32'h0, 1, "reset interrupts");
        check(ctrl_o | req_en_o | start_o | done_clr_o, 32'h0, 1, "reset outputs");

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            cycle(1'b1, VECS[i].word, VECS[i].addr, VECS[i].data, '0, '0);
            rd(VECS[i].raddr, v);
            check(v, VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
        end
        check(ctrl_o, 32'h0000_0024, 7, "ctrl_o mirror");
        check(req_en_o, 32'hF0F0_0001, 9, "req_en_o mirror");

        // R7 cancel bits drop after one cycle
        cycle(1'b1, 1'b1, 8'h00, 32'h0003_0004, '0, '0);
        rd(8'h00, v); check(v, 32'h0003_0004, 7, "cancel visible");
        @(negedge clk);
        rd(8'h00, v); check(v, 32'h0000_0004, 7, "cancel cleared");

        // R8 start and done-clear strobes
        cycle(1'b1, 1'b0, 8'h1D, 32'h0000_000C, '0, '0);
        check(start_o, 32'h0000_1000, 8, "start strobe");
        check(done_clr_o, 32'h0, 8, "no done strobe");
        @(negedge clk);
        check(start_o, 32'h0, 8, "start one cycle");
        cycle(1'b1, 1'b0, 8'h1C, 32'h0000_001E, '0, '0);
        check(done_clr_o, 32'h4000_0000, 8, "done strobe");
        @(negedge clk);
        check(done_clr_o, 32'h0, 8, "done one cycle");

        // R5 / R6 completion pending
        cycle(1'b0, 1'b0, 8'h00, 32'h0, 32'h0000_0208, '0);
        rd(8'h24, v); check(v, 32'h0000_0208, 5, "hw int set");
        check(32'(irq_o), 32'h1, 6, "irq raised");
        cycle(1'b1, 1'b0, 8'h1F, 32'h0000_0003, '0, '0);
        rd(8'h24, v); check(v, 32'h0000_0200, 4, "clear int ch3");
        check(32'(irq_o), 32'h1, 6, "irq still up");
        cycle(1'b1, 1'b0, 8'h1F, 32'h0000_0009, '0, '0);
        rd(8'h24, v); check(v, 32'h0, 4, "clear int ch9");
        check(32'(irq_o), 32'h0, 6, "irq dropped");

        // R5 hardware set beats a same-cycle clear
        cycle(1'b0, 1'b0, 8'h00, 32'h0, 32'h0000_0080, '0);
        cycle(1'b1, 1'b0, 8'h1F, 32'h0000_0007, 32'h0000_0180, '0);
        rd(8'h24, v); check(v, 32'h0000_0180, 5, "set wins over clear");
        cycle(1'b1, 1'b0, 8'h1F, 32'h0000_0007, 32'h0000_0100, '0);
        rd(8'h24, v); check(v, 32'h0000_0100, 5, "clear other bit while set");

        // R6 / R10 error path
        cycle(1'b1, 1'b0, 8'h19, 32'h0000_0004, '0, '0);
        cycle(1'b0, 1'b0, 8'h00, 32'h0, '0, 32'h0000_0044);
        rd(8'h2C, v); check(v, 32'h0000_0044, 5, "hw err set");
        check(32'(err_irq_o), 32'h0, 6, "err irq masked");
        rd(8'h04, v); check(v, 32'h8000_0002, 10, "status lowest channel");
        cycle(1'b0, 1'b0, 8'h00, 32'h0, '0, 32'h0000_0010);
        check(32'(err_irq_o), 32'h1, 6, "err irq enabled");
        rd(8'h04, v); check(v, 32'h8000_0004, 10, "status latest channel");
        cycle(1'b1, 1'b0, 8'h1E, 32'h0000_0004, '0, '0);
        rd(8'h2C, v); check(v, 32'h0000_0044, 4, "clear err ch4");
        check(32'(err_irq_o), 32'h0, 6, "err irq dropped");
        cycle(1'b1, 1'b0, 8'h1E, 32'h0000_0002, '0, '0);
        cycle(1'b1, 1'b0, 8'h1E, 32'h0000_0006, '0, '0);
        rd(8'h04, v); check(v, 32'h0000_0004, 10, "status flag clear");

        finish_run();
    end

endmodule